// File: doc/BRIEF.md
# EEPROM Page Write Sequencer

This block sits behind a two-wire serial slave and turns a run of received data bytes into one self-timed program cycle on a 256-byte non-volatile array. The bus side gives it a start address, then one strobe per data byte. Each byte lands in a 16-slot page buffer, and the slot pointer advances within the page. A STOP-derived commit strobe starts the program cycle. While the cycle runs, the block raises `busy` so the bus layer can withhold acknowledges. Near the end of the cycle it writes every slot that actually received a byte to the array through a RAM-style write port. An abort strobe throws the buffer away.

The array is split into aligned 16-byte pages. A transfer may start at any byte of a page. The low four address bits wrap, so a transfer never leaves its page, and bytes beyond the sixteenth replace earlier ones. When the write-protect level is high, the upper half of the array (address bit 7 set) is locked. `prot_reject` then tells the bus layer to refuse data for that page, and a commit starts no cycle. The length of the program cycle is the parameter `WR_CYCLES`, in system clocks, and it must be at least 16.

The controller has three states:
- `ST_IDLE` waits for an address load. A load moves it to `ST_COLLECT`.
- `ST_COLLECT` takes bytes. From there, an abort returns to `ST_IDLE`. A commit goes to `ST_PROG` when at least one byte is held and the page is not protected; otherwise a commit returns to `ST_IDLE` with the buffer cleared.
- `ST_PROG` counts the cycle. It returns to `ST_IDLE` on the last count, clearing the buffer.

Top module: `pgwr_seq`

## Requirements
- R1: While reset is held and right after it, `busy`, `prot_reject` and `mem_we` are 0.
- R2: An address load in `ST_IDLE` fixes the page (`addr_in[7:4]`) and the first slot (`addr_in[3:0]`). Each accepted byte goes to the current slot, and the slot then advances by one modulo 16. Every array write uses address {page, slot}.
- R3: When more than 16 bytes arrive before commit, a later byte for a slot replaces the earlier one. The array receives only the last value of each slot.
- R4: Only slots that received a byte are written. Every other address of the array, including the rest of the page, is not touched. After a cycle, all slot-valid bits are clear.
- R5: A commit accepted with at least one byte held and no protection raises `busy` from the next cycle for exactly `WR_CYCLES` cycles.
- R6: `mem_we` pulses only while `busy` is high, at most once per cycle. The writes fall in the last 16 cycles of the busy window, and busy cycle `WR_CYCLES-16+k` may write only slot k.
- R7: Address loads, bytes, commits and aborts that arrive while `busy` is high are ignored. They do not change the data written, the length of the window, or the state after it.
- R8: An abort in `ST_COLLECT` discards the buffer and returns to `ST_IDLE` with no write. A later commit without a new load does nothing.
- R9: With `wp_level` high and the page in the upper half (address bit 7 = 1), `prot_reject` is 1 while collecting. A commit then starts no cycle, writes nothing and discards the buffer.
- R10: With `wp_level` high and a page in the lower half, `prot_reject` stays 0 and the write proceeds normally.
- R11: A commit with no bytes received raises no `busy` and writes nothing.
- R12: Strobes that arrive in the same cycle during collection are ranked abort, then commit, then byte. A byte that arrives together with a commit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Start-address strobe, taken in ST_IDLE |
| addr_in | input | 8 | Start address of the transfer |
| byte_vld | input | 1 | Received-byte strobe |
| byte_data | input | 8 | Received byte |
| commit | input | 1 | STOP strobe that starts the program cycle |
| abort | input | 1 | Discard strobe |
| wp_level | input | 1 | Write-protect level for the upper half |
| busy | output | 1 | Program cycle in progress |
| prot_reject | output | 1 | Current page is protected; data must be refused |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 8 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The main function is tried with several transfers:
- A full aligned page, which shows the slot-to-address mapping.
- A single byte in mid-page, which shows that the neighbouring bytes are left alone.
- A start near the page end, which shows the wrap to the page base instead of a carry into the page bits.
- Twenty bytes, which shows that newer data replaces older data.
- Protected and unprotected transfers in the upper half with write protect high, and a lower-half transfer with write protect high, which separate the address test from the level test.
- An empty commit, which shows that no cycle starts.

Directed runs then fire every strobe during the busy window, abort before commit, and combine strobes in one cycle to fix the priority order. A model of the array built from the write port is compared in full with an expected image after each run.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_PROG    = 2'd2
    } seq_state_t;

endpackage

// File: rtl/pgwr_buffer.sv
module pgwr_buffer #(
    parameter int SLOT_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              any_valid
);

    localparam int SLOTS = 1 << SLOT_W;

    logic [SLOTS-1:0]  vld_vec;
    logic [DATA_W-1:0] data_arr [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic              vld_r;
        logic [DATA_W-1:0] dat_r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_r <= 1'b0;
                dat_r <= '0;
            end else if (clr) begin
                vld_r <= 1'b0;
            end else if (wr_en && (wr_slot == SLOT_W'(s))) begin
                vld_r <= 1'b1;
                dat_r <= wr_data;
            end
        end

        assign vld_vec[s]  = vld_r;
        assign data_arr[s] = dat_r;
    end

    assign rd_data   = data_arr[rd_slot];
    assign rd_valid  = vld_vec[rd_slot];
    assign any_valid = |vld_vec;

    // R4
    slot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !any_valid);

    // R2
    slot_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> any_valid);

endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
    parameter int LIMIT = 100000,
    parameter int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LIMIT - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= '0;
        end else if (run && (cnt != LAST_CNT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = run && (cnt == LAST_CNT);

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= LAST_CNT));

endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
    import pgwr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SLOT_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     addr_load,
    input  logic [ADDR_W-1:0]        addr_in,
    input  logic                     byte_vld,
    input  logic                     commit,
    input  logic                     abort,
    input  logic                     wp_level,
    input  logic                     any_valid,
    input  logic                     tmr_last,
    output logic                     buf_wr,
    output logic [SLOT_W-1:0]        buf_slot,
    output logic                     buf_clr,
    output logic                     tmr_start,
    output logic                     busy,
    output logic                     prot_reject,
    output logic [ADDR_W-SLOT_W-1:0] page
);

    localparam int PAGE_W = ADDR_W - SLOT_W;

    seq_state_t        state_q, state_d;
    logic [SLOT_W-1:0] ptr_q;
    logic [PAGE_W-1:0] page_q;
    logic              prot_hit;
    logic              take_byte;
    logic              take_commit;
    logic              go_prog;

    assign prot_hit    = wp_level && page_q[PAGE_W-1];
    assign take_byte   = (state_q == ST_COLLECT) && byte_vld && !commit && !abort;
    assign take_commit = (state_q == ST_COLLECT) && commit && !abort;
    assign go_prog     = take_commit && any_valid && !prot_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (addr_load) state_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (abort)            state_d = ST_IDLE;
                else if (go_prog)     state_d = ST_PROG;
                else if (take_commit) state_d = ST_IDLE;
            end
            ST_PROG: begin
                if (tmr_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            page_q <= '0;
        end else if ((state_q == ST_IDLE) && addr_load) begin
            ptr_q  <= addr_in[SLOT_W-1:0];
            page_q <= addr_in[ADDR_W-1:SLOT_W];
        end else if (take_byte) begin
            ptr_q  <= ptr_q + 1'b1;
        end
    end

    always_comb begin
        buf_wr      = 1'b0;
        buf_clr     = 1'b0;
        tmr_start   = 1'b0;
        busy        = 1'b0;
        prot_reject = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_COLLECT: begin
                buf_wr      = take_byte;
                buf_clr     = abort || (take_commit && !go_prog);
                tmr_start   = go_prog;
                prot_reject = prot_hit;
            end
            ST_PROG: begin
                busy    = 1'b1;
                buf_clr = tmr_last;
            end
            default: begin
            end
        endcase
    end

    assign buf_slot = ptr_q;
    assign page     = page_q;

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && !tmr_last) |=> (state_q == ST_PROG));

    // R5
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && tmr_last) |=> (state_q == ST_IDLE));

    // R9
    prot_no_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COLLECT && commit && !abort && prot_hit) |=> (state_q == ST_IDLE));

    // R8
    abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COLLECT && abort) |=> (state_q == ST_IDLE && !any_valid));

endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int SLOT_W    = 4,
    parameter int WR_CYCLES = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              commit,
    input  logic              abort,
    input  logic              wp_level,
    output logic              busy,
    output logic              prot_reject,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);

    localparam int SLOTS  = 1 << SLOT_W;
    localparam int PAGE_W = ADDR_W - SLOT_W;
    localparam int CNT_W  = $clog2(WR_CYCLES + 1);
    localparam int FLUSH_START = (WR_CYCLES > SLOTS) ? (WR_CYCLES - SLOTS) : 0;
    localparam logic [CNT_W-1:0] FLUSH_AT = CNT_W'(FLUSH_START);

    logic              buf_wr;
    logic [SLOT_W-1:0] buf_slot;
    logic              buf_clr;
    logic              tmr_start;
    logic              tmr_last;
    logic [CNT_W-1:0]  tmr_cnt;
    logic              any_valid;
    logic [PAGE_W-1:0] page;
    logic [CNT_W-1:0]  flush_off;
    logic [SLOT_W-1:0] rd_slot;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid;
    logic              in_flush;

    pgwr_ctrl #(
        .ADDR_W (ADDR_W),
        .SLOT_W (SLOT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_load   (addr_load),
        .addr_in     (addr_in),
        .byte_vld    (byte_vld),
        .commit      (commit),
        .abort       (abort),
        .wp_level    (wp_level),
        .any_valid   (any_valid),
        .tmr_last    (tmr_last),
        .buf_wr      (buf_wr),
        .buf_slot    (buf_slot),
        .buf_clr     (buf_clr),
        .tmr_start   (tmr_start),
        .busy        (busy),
        .prot_reject (prot_reject),
        .page        (page)
    );

    pgwr_buffer #(
        .SLOT_W (SLOT_W),
        .DATA_W (DATA_W)
    ) u_buffer (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (buf_wr),
        .wr_slot   (buf_slot),
        .wr_data   (byte_data),
        .clr       (buf_clr),
        .rd_slot   (rd_slot),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .any_valid (any_valid)
    );

    pgwr_timer #(
        .LIMIT (WR_CYCLES),
        .CNT_W (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .run   (busy),
        .cnt   (tmr_cnt),
        .last  (tmr_last)
    );

    assign flush_off = tmr_cnt - FLUSH_AT;
    assign rd_slot   = flush_off[SLOT_W-1:0];
    assign in_flush  = busy && (tmr_cnt >= FLUSH_AT);
    assign mem_we    = in_flush && rd_valid;
    assign mem_addr  = {page, rd_slot};
    assign mem_wdata = rd_data;

    // R6
    we_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R5
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(commit));

    // R6
    page_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_addr[ADDR_W-1:SLOT_W]));

endmodule

// File: tb/pgwr_seq_bench.sv
`timescale 1ns/1ps
module pgwr_seq_bench;

    localparam int WR = 24;
    localparam int NV = 8;
    // {addr[7:0], nbytes[5:0], seed[7:0], wp}
    localparam logic [22:0] VEC [NV] = '{
        {8'h00, 6'd16, 8'h10, 1'b0},
        {8'h35, 6'd1,  8'hA5, 1'b0},
        {8'h4C, 6'd7,  8'h20, 1'b0},
        {8'h70, 6'd20, 8'h40, 1'b0},
        {8'h90, 6'd5,  8'h60, 1'b1},
        {8'h92, 6'd3,  8'h70, 1'b0},
        {8'h2F, 6'd4,  8'h80, 1'b1},
        {8'h50, 6'd0,  8'h00, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_load = 1'b0;
    logic [7:0] addr_in = '0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = '0;
    logic       commit = 1'b0;
    logic       abort = 1'b0;
    logic       wp_level = 1'b0;
    logic       busy, prot_reject, mem_we;
    logic [7:0] mem_addr, mem_wdata;

    int n_chk = 0;
    int n_bad = 0;
    int viol = 0;
    int wr_seen = 0;
    int wr_exp = 0;
    int busy_age = 0;
    bit done = 1'b0;

    logic [7:0] model_mem [256];
    logic [7:0] ref_mem   [256];

    always #2 clk = ~clk;

    pgwr_seq #(.WR_CYCLES(WR)) u_pgwr_seq (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .byte_vld(byte_vld), .byte_data(byte_data), .commit(commit), .abort(abort),
        .wp_level(wp_level), .busy(busy), .prot_reject(prot_reject),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // array model fed only from the write port; R6 timing monitor
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) model_mem[i] <= 8'(i) ^ 8'h5A;
            busy_age <= 0;
        end else begin
            if (mem_we) begin
                model_mem[mem_addr] <= mem_wdata;
                wr_seen <= wr_seen + 1;
                if (!busy || busy_age < WR - 16 || 4'(busy_age - (WR - 16)) != mem_addr[3:0])
                    viol <= viol + 1;
            end
            busy_age <= busy ? busy_age + 1 : 0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int mem_diff();
        int d = 0;
        for (int i = 0; i < 256; i++) if (model_mem[i] !== ref_mem[i]) d++;
        return d;
    endfunction

    task automatic do_load(input logic [7:0] a);
        addr_load = 1'b1; addr_in = a;
        @(negedge clk);
        addr_load = 1'b0;
    endtask

    task automatic do_byte(input logic [7:0] d);
        byte_vld = 1'b1; byte_data = d;
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic do_commit();
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 4 * WR) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic run_page(input logic [7:0] a, input int nb, input logic [7:0] seed,
                            input logic wp);
        logic [7:0] sv [16];
        bit         sq [16];
        logic [3:0] p;
        bit         prot, go;
        int         nbusy, nv;
        for (int i = 0; i < 16; i++) sq[i] = 1'b0;
        wp_level = wp;
        prot = wp && a[7];
        do_load(a);
        // R9 R10: protect flag while collecting
        check(prot_reject == prot, prot ? "R9" : "R10", prot_reject, prot);
        p = a[3:0];
        for (int k = 0; k < nb; k++) begin
            logic [7:0] d = seed + 8'(k * 7);
            do_byte(d);
            sv[p] = d; sq[p] = 1'b1; p = p + 4'd1;
        end
        do_commit();
        go = (nb > 0) && !prot;
        count_busy(nbusy);
        // R5 R11: busy window length
        check(nbusy == (go ? WR : 0), go ? "R5" : "R11", nbusy, go ? WR : 0);
        nv = 0;
        if (go)
            for (int i = 0; i < 16; i++)
                if (sq[i]) begin
                    ref_mem[{a[7:4], 4'(i)}] = sv[i];
                    nv++;
                end
        wr_exp += nv;
        repeat (2) @(negedge clk);
        // R2 R3 R4: array image
        check(mem_diff() == 0, nb > 16 ? "R3" : "R2", mem_diff(), 0);
        wp_level = 1'b0;
    endtask

    initial begin
        int nb;
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'(i) ^ 8'h5A;
        repeat (3) @(negedge clk);
        // R1 during reset
        check(!busy && !prot_reject && !mem_we, "R1", {busy, prot_reject, mem_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !prot_reject && !mem_we, "R1", {busy, prot_reject, mem_we}, 0);

        for (int v = 0; v < NV; v++)
            run_page(VEC[v][22:15], int'(VEC[v][14:9]), VEC[v][8:1], VEC[v][0]);

        // R4: valid bits cleared after a cycle, empty commit does nothing
        do_load(8'h00);
        do_commit();
        count_busy(nb);
        check(nb == 0, "R4", nb, 0);

        // R7: every strobe during busy ignored
        do_load(8'h18);
        do_byte(8'hC1);
        do_byte(8'hC2);
        do_commit();
        nb = 0;
        while (busy && nb < 4 * WR) begin
            if (nb < 3) begin
                addr_load = 1'b1; addr_in = 8'h1C; byte_vld = 1'b1; byte_data = 8'hEE;
                commit = 1'b1; abort = (nb == 1);
            end else begin
                addr_load = 1'b0; byte_vld = 1'b0; commit = 1'b0; abort = 1'b0;
            end
            nb++;
            @(negedge clk);
        end
        addr_load = 1'b0; byte_vld = 1'b0; commit = 1'b0; abort = 1'b0;
        check(nb == WR, "R7", nb, WR);
        ref_mem[8'h18] = 8'hC1; ref_mem[8'h19] = 8'hC2; wr_exp += 2;
        repeat (2) @(negedge clk);
        check(mem_diff() == 0, "R7", mem_diff(), 0);
        do_commit();
        count_busy(nb);
        check(nb == 0, "R7", nb, 0);

        // R8: abort discards, later commit without load is inert
        do_load(8'h60);
        do_byte(8'h11); do_byte(8'h22); do_byte(8'h33);
        abort = 1'b1; @(negedge clk); abort = 1'b0;
        do_commit();
        count_busy(nb);
        check(nb == 0, "R8", nb, 0);
        check(mem_diff() == 0, "R8", mem_diff(), 0);
        do_load(8'h61);
        do_byte(8'h44);
        do_commit();
        count_busy(nb);
        ref_mem[8'h61] = 8'h44; wr_exp += 1;
        repeat (2) @(negedge clk);
        check(mem_diff() == 0, "R8", mem_diff(), 0);

        // R12: abort outranks commit
        do_load(8'h40);
        do_byte(8'h99);
        abort = 1'b1; commit = 1'b1; @(negedge clk); abort = 1'b0; commit = 1'b0;
        count_busy(nb);
        check(nb == 0, "R12", nb, 0);
        // R12: commit outranks a same-cycle byte
        do_load(8'hA0);
        do_byte(8'h01); do_byte(8'h02);
        commit = 1'b1; byte_vld = 1'b1; byte_data = 8'h03;
        @(negedge clk);
        commit = 1'b0; byte_vld = 1'b0;
        count_busy(nb);
        check(nb == WR, "R12", nb, WR);
        ref_mem[8'hA0] = 8'h01; ref_mem[8'hA1] = 8'h02; wr_exp += 2;
        repeat (2) @(negedge clk);
        check(mem_diff() == 0, "R12", mem_diff(), 0);

        // R6: write placement and count
        check(viol == 0, "R6", viol, 0);
        check(wr_seen == wr_exp, "R6", wr_seen, wr_exp);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule